// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 96 interrupt request lines into three banks of 32, records each request in a pending bit, qualifies it with per-source enable and mask bits, and asserts one registered interrupt output toward a processor. A vector register reports the lowest-numbered source that is both pending and allowed through, so the handler can read a single word to find the next source to serve.

Source 0 is special: it is the external line, and its pending bit is a sticky latch that software must clear by writing one. Its trigger condition is chosen in a configuration register (high level, rising edge, low level or falling edge). All other sources are level sources: their pending bit mirrors the synchronised input. Because the vector for source 0 is zero, which is also what the register returns when nothing is active, a handler that reads zero has to look at pending bit 0 to tell the two cases apart. A protection bit can lock the register file so that only privileged writes take effect.

The register port is a 32-bit word-addressed port with separate write and read strobes; read data is registered and appears on the clock edge that samples the read strobe.

Top module: `intc_top`

## Requirements
- R1: After reset the interrupt output is low and every mapped register (vector 0x00, protection 0x02, trigger config 0x03, pending 0x04-0x06, enable 0x10-0x12, mask 0x14-0x16, word addresses) reads zero.
- R2: The vector register at word 0x00 returns the lowest active source number in bits [8:2], bits [1:0] and [31:9] zero, and reads zero when no source is active.
- R3: A source is active only when its pending bit is 1, its enable bit (bank b at 0x10+b, bit n%32) is 1 and its mask bit (0x14+b) is 0.
- R4: The pending bit of source 0 (pending word 0x04 bit 0) stays set after its input drops; writing 1 to that bit clears it, writing 0 leaves it.
- R5: For sources 1 to 95 the pending bit (word 0x04 + n/32, bit n%32) equals the input level after a two-flop synchroniser, and is readable three clock edges after the input changes; writing ones to those bits has no effect.
- R6: The interrupt output is the registered OR of all active sources; it rises and falls one clock edge after the active set changes.
- R7: Bit 0 of word 0x02 turns protection on; while it is 1, writes with the privileged input low are ignored, including writes to word 0x02 itself.
- R8: Bits [1:0] of word 0x03 pick the source 0 trigger: 0 high level, 1 rising edge, 2 low level, 3 falling edge; an edge mode does not re-set the bit while the level merely persists.
- R9: When a write-one clear of source 0 and its trigger condition fall in the same cycle, the pending bit stays set.
- R10: Read data is captured on the edge that samples the read strobe and held otherwise; the fast pending words 0x08-0x0A and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 96 | Asynchronous interrupt request lines, bit n is source n |
| privIn | input | 1 | High when the current write is privileged |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 6 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The two functions that can meet in one cycle are the software clear of source 0 and its hardware trigger, and the bench forces this by holding the external line high in level mode while writing one to pending bit 0, then reading back a set bit. The same collision is replayed in rising-edge mode with the line still high, where the clear must win because no new edge occurs. A second overlap, a register write arriving while protection is on, is provoked with the privileged input low and judged by reading the targeted registers back unchanged.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // word addresses of the register file
  localparam int A_VECTOR  = 'h00;
  localparam int A_PROTECT = 'h02;
  localparam int A_EXTCFG  = 'h03;
  localparam int A_PEND    = 'h04;
  localparam int A_FAST    = 'h08;
  localparam int A_ENABLE  = 'h10;
  localparam int A_MASK    = 'h14;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trigMode_t;

  // control -> datapath strobes
  typedef struct packed {
    logic      src0Clr;
    trigMode_t trigMode;
  } ctrlStrobe_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 96,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SRC    = NUM_BANKS * BANK_W,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] enableBits,
  input  logic [NUM_SRC-1:0] maskBits,
  output logic [NUM_SRC-1:0] pendBits,
  output logic [IDX_W-1:0]   vecIdx,
  output logic               vecAny,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] lvl;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] active;
  logic               lvl0Prev;
  logic               trig0;

  intc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (irqLines),
    .dout (lvl)
  );

  always_ff @(posedge clk) begin
    if (!rstN) lvl0Prev <= 1'b0;
    else       lvl0Prev <= lvl[0];
  end

  always_comb begin
    unique case (strobe.trigMode)
      TRIG_HIGH: trig0 = lvl[0];
      TRIG_RISE: trig0 = lvl[0] & ~lvl0Prev;
      TRIG_LOW:  trig0 = ~lvl[0];
      TRIG_FALL: trig0 = ~lvl[0] & lvl0Prev;
      default:   trig0 = 1'b0;
    endcase
  end

  // source 0 latches (set beats clear), others follow the level
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      pend[0]           <= trig0 | (pend[0] & ~strobe.src0Clr);
      pend[NUM_SRC-1:1] <= lvl[NUM_SRC-1:1];
    end
  end

  assign pendBits = pend;
  assign active   = pend & enableBits & ~maskBits;

  // lowest index wins
  always_comb begin
    vecIdx = '0;
    vecAny = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        vecIdx = IDX_W'(i);
        vecAny = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |active;
  end

  assert_vec_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    vecAny |-> active[vecIdx]);

  assert_vec_lowest_R2: assert property (@(posedge clk) disable iff (!rstN)
    vecAny |-> ((active & ((NUM_SRC'(1) << vecIdx) - NUM_SRC'(1))) == '0));

  assert_src0_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pend[0]) && !$past(strobe.src0Clr)) |-> pend[0]);

  assert_clear_loses_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trig0 && strobe.src0Clr) |=> pend[0]);

  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> ($past(active) == '0));

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 6,
  localparam int NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic               privIn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] pendBits,
  input  logic [IDX_W-1:0]   vecIdx,
  input  logic               vecAny,
  output ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] enableBits,
  output logic [NUM_SRC-1:0] maskBits,
  output logic [BANK_W-1:0]  rdData
);

  logic        protOn;
  trigMode_t   trigMode;
  logic        wrOk;
  logic [BANK_W-1:0] rdNext;

  assign wrOk = wrEn && (!protOn || privIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protOn   <= 1'b0;
      trigMode <= TRIG_HIGH;
    end else if (wrOk) begin
      if (addr == ADDR_W'(A_PROTECT)) protOn   <= wrData[0];
      if (addr == ADDR_W'(A_EXTCFG))  trigMode <= trigMode_t'(wrData[1:0]);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [BANK_W-1:0] enR;
    logic [BANK_W-1:0] mkR;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        enR <= '0;
        mkR <= '0;
      end else if (wrOk) begin
        if (addr == ADDR_W'(A_ENABLE + b)) enR <= wrData;
        if (addr == ADDR_W'(A_MASK + b))   mkR <= wrData;
      end
    end
    assign enableBits[b*BANK_W +: BANK_W] = enR;
    assign maskBits[b*BANK_W +: BANK_W]   = mkR;
  end

  assign strobe.src0Clr  = wrOk && (addr == ADDR_W'(A_PEND)) && wrData[0];
  assign strobe.trigMode = trigMode;

  always_comb begin
    rdNext = '0;
    if (addr == ADDR_W'(A_VECTOR))  rdNext = vecAny ? BANK_W'({vecIdx, 2'b00}) : '0;
    if (addr == ADDR_W'(A_PROTECT)) rdNext = BANK_W'(protOn);
    if (addr == ADDR_W'(A_EXTCFG))  rdNext = BANK_W'(trigMode);
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(A_PEND + b))   rdNext = pendBits[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(A_FAST + b))   rdNext = '0;
      if (addr == ADDR_W'(A_ENABLE + b)) rdNext = enableBits[b*BANK_W +: BANK_W];
      if (addr == ADDR_W'(A_MASK + b))   rdNext = maskBits[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

  assert_prot_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && protOn && !privIn) |=>
      ($stable(enableBits) && $stable(maskBits) && $stable(protOn) && $stable(trigMode)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_vec_format_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(A_VECTOR)) |=>
      (rdData[1:0] == 2'b00 && rdData[BANK_W-1:IDX_W+2] == '0));

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SRC    = NUM_BANKS * BANK_W,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic               privIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  wrData,
  output logic [BANK_W-1:0]  rdData,
  output logic               irqOut
);

  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] enableBits;
  logic [NUM_SRC-1:0] maskBits;
  logic [NUM_SRC-1:0] pendBits;
  logic [IDX_W-1:0]   vecIdx;
  logic               vecAny;

  intc_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .privIn     (privIn),
    .addr       (addr),
    .wrData     (wrData),
    .pendBits   (pendBits),
    .vecIdx     (vecIdx),
    .vecAny     (vecAny),
    .strobe     (strobe),
    .enableBits (enableBits),
    .maskBits   (maskBits),
    .rdData     (rdData)
  );

  intc_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .irqLines   (irqLines),
    .strobe     (strobe),
    .enableBits (enableBits),
    .maskBits   (maskBits),
    .pendBits   (pendBits),
    .vecIdx     (vecIdx),
    .vecAny     (vecAny),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;

  localparam logic [5:0] VEC = 6'h00, PROT = 6'h02, EXT = 6'h03;
  localparam logic [5:0] PND0 = 6'h04, PND1 = 6'h05, PND2 = 6'h06;
  localparam logic [5:0] FST1 = 6'h09, EN0 = 6'h10, EN1 = 6'h11, EN2 = 6'h12;
  localparam logic [5:0] MK0 = 6'h14, MK1 = 6'h15, MK2 = 6'h16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [95:0] irqLines = '0;
  logic        privIn = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #2.5 clk = ~clk;

  intc_top dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .privIn(privIn),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic p);
    addr = a; wrData = d; privIn = p; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; privIn = 1'b0;
  endtask

  // driver: push the expected value, then issue the read
  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: a read sampled at the last edge is compared here
  always @(posedge clk) rdSeen <= rdEn;

  initial begin
    forever begin
      @(negedge clk);
      if (rdSeen) begin
        if (expQ.size() == 0) chk("scoreboard-underflow", 32'h1, 32'h0);
        else chk(tagQ.pop_front(), rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 irqOut", {31'b0, irqOut}, 32'h0);
    rd(VEC, 0, "R1 vector"); rd(PROT, 0, "R1 prot"); rd(EXT, 0, "R1 ext");
    rd(PND0, 0, "R1 pend0"); rd(PND1, 0, "R1 pend1"); rd(PND2, 0, "R1 pend2");
    rd(EN0, 0, "R1 en0"); rd(EN1, 0, "R1 en1"); rd(EN2, 0, "R1 en2");
    rd(MK0, 0, "R1 mask0"); rd(MK1, 0, "R1 mask1"); rd(MK2, 0, "R1 mask2");

    // R5 level source pends, R3 not enabled
    irqLines[37] = 1'b1;
    idle(3);
    rd(PND1, 32'h20, "R5 pend37");
    rd(VEC, 0, "R3 disabled vector");
    chk("R3 irqOut disabled", {31'b0, irqOut}, 32'h0);

    // R2 vector, R6 output
    wr(EN1, 32'h20, 1'b0);
    rd(VEC, 37 * 4, "R2 vector37");
    idle(2);
    chk("R6 irqOut high", {31'b0, irqOut}, 32'h1);

    // R3 mask
    wr(MK1, 32'h20, 1'b0);
    rd(VEC, 0, "R3 masked vector");
    idle(2);
    chk("R3 irqOut masked", {31'b0, irqOut}, 32'h0);
    wr(MK1, 32'h0, 1'b0);
    rd(MK1, 0, "R3 mask1 readback");

    // R2 lowest first
    wr(EN1, 32'h120, 1'b0);
    wr(EN2, 32'h40, 1'b0);
    irqLines[40] = 1'b1; irqLines[70] = 1'b1;
    idle(3);
    rd(VEC, 37 * 4, "R2 lowest of three");
    irqLines[37] = 1'b0;
    idle(3);
    rd(VEC, 40 * 4, "R2 next lowest");
    rd(PND2, 32'h40, "R5 pend70");

    // R5 write-one has no effect on level sources
    wr(PND1, 32'hFFFF_FFFF, 1'b0);
    rd(PND1, 32'h100, "R5 write-one ignored");

    // R6 exact fall timing
    irqLines[40] = 1'b0; irqLines[70] = 1'b0;
    idle(3);
    chk("R6 irqOut one more cycle", {31'b0, irqOut}, 32'h1);
    idle(1);
    chk("R6 irqOut fallen", {31'b0, irqOut}, 32'h0);
    rd(VEC, 0, "R2 empty vector");

    // R4 sticky source 0
    wr(EN0, 32'h1, 1'b0);
    irqLines[0] = 1'b1;
    idle(3);
    irqLines[0] = 1'b0;
    idle(4);
    rd(PND0, 32'h1, "R4 sticky");
    rd(VEC, 0, "R2 source0 reads zero");
    chk("R4 irqOut from source0", {31'b0, irqOut}, 32'h1);
    wr(PND0, 32'hFFFF_FFFE, 1'b0);
    rd(PND0, 32'h1, "R4 write zero keeps");
    wr(PND0, 32'h1, 1'b0);
    rd(PND0, 32'h0, "R4 write one clears");
    idle(1);
    chk("R4 irqOut cleared", {31'b0, irqOut}, 32'h0);

    // R9 clear collides with level trigger
    irqLines[0] = 1'b1;
    idle(3);
    wr(PND0, 32'h1, 1'b0);
    rd(PND0, 32'h1, "R9 set beats clear");
    irqLines[0] = 1'b0;
    idle(3);
    wr(PND0, 32'h1, 1'b0);
    rd(PND0, 32'h0, "R9 clear after drop");

    // R8 rising edge
    wr(EXT, 32'h1, 1'b0);
    rd(EXT, 32'h1, "R8 ext readback");
    irqLines[0] = 1'b1;
    idle(3);
    rd(PND0, 32'h1, "R8 rising edge");
    wr(PND0, 32'h1, 1'b0);
    rd(PND0, 32'h0, "R8 edge not re-set");
    irqLines[0] = 1'b0;
    idle(3);
    // R8 low level
    wr(EXT, 32'h2, 1'b0);
    idle(2);
    rd(PND0, 32'h1, "R8 low level");
    wr(EXT, 32'h3, 1'b0);
    wr(PND0, 32'h1, 1'b0);
    rd(PND0, 32'h0, "R8 falling idle");
    // R8 falling edge
    irqLines[0] = 1'b1;
    idle(3);
    rd(PND0, 32'h0, "R8 no pend on rise");
    irqLines[0] = 1'b0;
    idle(3);
    rd(PND0, 32'h1, "R8 falling edge");
    wr(EXT, 32'h0, 1'b0);
    wr(PND0, 32'h1, 1'b0);
    rd(PND0, 32'h0, "R8 cleared");

    // R7 protection
    wr(PROT, 32'h1, 1'b0);
    rd(PROT, 32'h1, "R7 prot on");
    wr(EN0, 32'hFFFF, 1'b0);
    rd(EN0, 32'h1, "R7 unprivileged ignored");
    wr(EN0, 32'hFFFF, 1'b1);
    rd(EN0, 32'hFFFF, "R7 privileged accepted");
    wr(PROT, 32'h0, 1'b0);
    rd(PROT, 32'h1, "R7 prot self-locked");
    wr(PROT, 32'h0, 1'b1);
    rd(PROT, 32'h0, "R7 prot off");

    // R10 fast and unmapped words
    irqLines[33] = 1'b1;
    idle(3);
    rd(FST1, 32'h0, "R10 fast pend zero");
    rd(6'h3F, 32'h0, "R10 unmapped zero");
    rd(PND1, 32'h2, "R5 pend33");
    irqLines[33] = 1'b0;

    idle(3);
    chk("R10 scoreboard drained", expQ.size(), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule